// File: doc/BRIEF.md
# Watchdog Counter with Reset Prewarning

This block is the timing core of a system watchdog. A 16-bit up-counter advances once per enable pulse from a prescaler. The prescaler divides the system clock by one of two power-of-two ratios, chosen by a select input. Software keeps the system alive by servicing the counter, which loads a programmable start value. If the counter runs past its all-ones value, or the password unit reports a bad access, the block does not reset the system straight away. It first raises a one-cycle non-maskable interrupt. It then restarts the counter from a fixed value close to the top and requests system reset when that second interval expires.

The reset request stays high until the system reset comes back into the block. The system reset returns the counter and the phase to their idle state. It does not touch the double-reset tracking, which only the power-on reset clears. If the block asks for reset twice and no proper control access is reported in between, it raises a sticky hold-in-reset flag. That flag stays high until the next power-on reset.

Top module: `wdt_prewarn`

## Requirements
- R1: After power-on reset (`por_n` low), `nmi`, `rst_req` and `hold_rst` are all low.
- R2: The counter advances once every `DIV_LO` clocks while `slow_sel` is 0 and once every `DIV_HI` clocks while it is 1. The prescaler starts from zero when system reset is released.
- R3: A service (`svc` high for one cycle) loads `reload_val` into the counter. Counting starts from the release of system reset, with `svc` high in the first cycle after release. After 2^16 − `reload_val` enables the counter wraps past 16'hFFFF, and `nmi` goes high for exactly one clock cycle. With `DIV_LO` = D, that cycle is D × (2^16 − `reload_val`) cycles after the release.
- R4: When the prewarning phase starts, the counter loads the fixed value 2^16 − 256 (16'hFF00). `rst_req` rises 256 enables after the `nmi` pulse and stays high until `sys_rst` is asserted.
- R5: During the prewarning phase, `svc` and `acc_err` are ignored. They produce no further `nmi` pulse and do not move the `rst_req` time.
- R6: `acc_err` during normal counting starts the prewarning phase at once: `nmi` is high in the following cycle.
- R7: With `wd_dis` high, normal counting stops and no overflow `nmi` occurs. `acc_err` still starts the prewarning phase, and that phase runs to `rst_req` even while `wd_dis` stays high.
- R8: If a second `rst_req` occurs with no `proper_acc` pulse since the previous one, `hold_rst` goes high. A `proper_acc` pulse between the two prevents this.
- R9: `hold_rst` and the pending double-reset mark are cleared only by `por_n`. Neither `sys_rst` nor `proper_acc` clears `hold_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| sys_rst | input | 1 | System reset, synchronous, active high; clears counter, prescaler and phase |
| svc | input | 1 | Service pulse; loads the reload value |
| wd_dis | input | 1 | Stops normal counting when high |
| slow_sel | input | 1 | Prescaler select: 0 divides by DIV_LO, 1 by DIV_HI |
| reload_val | input | CNT_W | User reload value for normal counting |
| acc_err | input | 1 | Access error reported by the password logic |
| proper_acc | input | 1 | Proper control access completed |
| nmi | output | 1 | One-cycle non-maskable interrupt prewarning |
| rst_req | output | 1 | System reset request, held until sys_rst |
| hold_rst | output | 1 | Sticky hold-in-reset after a double watchdog reset |

## Verification
Most wrong internal states appear at the ports only as timing. A prescaler that picks the wrong ratio, or a counter loaded with the wrong value, moves the `nmi` pulse by a whole number of enable periods. A wrong prewarning reload moves `rst_req` by the same kind of step. The scoreboard therefore predicts the exact cycle of each event, and one step of error fails the check. A double-reset mark that is lost or left set stays hidden until the next `rst_req`, so `hold_rst` is sampled after every reset request and again after each kind of reset is applied.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   typedef enum logic [1:0] {
      PH_RUN   = 2'd0,
      PH_WARN  = 2'd1,
      PH_RESET = 2'd2
   } wdt_phase_e;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
   parameter int unsigned DIV_LO = 256,
   parameter int unsigned DIV_HI = 16384
) (
   input  logic clk,
   input  logic por_n,
   input  logic sys_rst,
   input  logic slow_sel,
   output logic tick
);
   localparam int unsigned LO_W = $clog2(DIV_LO);
   localparam int unsigned HI_W = $clog2(DIV_HI);

   generate
      if (DIV_LO < 2 || (DIV_LO & (DIV_LO - 1)) != 0)
         $error("DIV_LO must be a power of two of at least 2");
      if (DIV_HI < DIV_LO || (DIV_HI & (DIV_HI - 1)) != 0)
         $error("DIV_HI must be a power of two not below DIV_LO");
   endgenerate

   logic [HI_W-1:0] pcnt;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)       pcnt <= '0;
      else if (sys_rst) pcnt <= '0;
      else              pcnt <= pcnt + 1'b1;
   end

   generate
      if (DIV_HI == DIV_LO) begin : g_single
         assign tick = &pcnt;
      end else begin : g_dual
         assign tick = slow_sel ? (&pcnt) : (&pcnt[LO_W-1:0]);
      end
   endgenerate
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             clr,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             inc,
   output logic             at_max
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)    cnt <= '0;
      else if (clr)  cnt <= '0;
      else if (load) cnt <= load_val;
      else if (inc)  cnt <= cnt + 1'b1;
   end

   assign at_max = &cnt;
endmodule

// File: rtl/wdt_escalate.sv
module wdt_escalate
   import wdt_pkg::*;
(
   input  logic       clk,
   input  logic       por_n,
   input  logic       sys_rst,
   input  logic       tick,
   input  logic       at_max,
   input  logic       svc,
   input  logic       wd_dis,
   input  logic       acc_err,
   input  logic       proper_acc,
   output wdt_phase_e phase,
   output logic       go_warn,
   output logic       nmi,
   output logic       rst_req,
   output logic       hold_rst
);
   logic go_rst;
   logic armed;

   assign go_warn = (phase == PH_RUN) &&
                    (acc_err || (tick && at_max && !wd_dis && !svc));
   assign go_rst  = (phase == PH_WARN) && tick && at_max;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         phase <= PH_RUN;
         nmi   <= 1'b0;
      end else if (sys_rst) begin
         phase <= PH_RUN;
         nmi   <= 1'b0;
      end else begin
         nmi <= go_warn;
         if (go_warn)     phase <= PH_WARN;
         else if (go_rst) phase <= PH_RESET;
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         armed    <= 1'b0;
         hold_rst <= 1'b0;
      end else if (go_rst && !sys_rst) begin
         if (armed) hold_rst <= 1'b1;
         armed <= 1'b1;
      end else if (proper_acc) begin
         armed <= 1'b0;
      end
   end

   assign rst_req = (phase == PH_RESET);
endmodule

// File: rtl/wdt_prewarn.sv
module wdt_prewarn
   import wdt_pkg::*;
#(
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned DIV_LO   = 256,
   parameter int unsigned DIV_HI   = 16384,
   parameter int unsigned WARN_GAP = 256
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             sys_rst,
   input  logic             svc,
   input  logic             wd_dis,
   input  logic             slow_sel,
   input  logic [CNT_W-1:0] reload_val,
   input  logic             acc_err,
   input  logic             proper_acc,
   output logic             nmi,
   output logic             rst_req,
   output logic             hold_rst
);
   localparam logic [CNT_W-1:0] WARN_RELOAD = CNT_W'((64'd1 << CNT_W) - 64'(WARN_GAP));

   generate
      if (CNT_W < 2 || CNT_W > 32)
         $error("CNT_W out of range");
      if (WARN_GAP < 1 || 64'(WARN_GAP) > (64'd1 << CNT_W))
         $error("WARN_GAP must fit in the counter");
   endgenerate

   wdt_phase_e       phase;
   logic             tick, at_max, go_warn;
   logic             counting, load, inc;
   logic [CNT_W-1:0] load_val;

   wdt_prescaler #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_pre (
      .clk(clk), .por_n(por_n), .sys_rst(sys_rst),
      .slow_sel(slow_sel), .tick(tick)
   );

   assign counting = ((phase == PH_RUN) && !wd_dis) || (phase == PH_WARN);
   assign load     = go_warn || ((phase == PH_RUN) && svc);
   assign load_val = go_warn ? WARN_RELOAD : reload_val;
   assign inc      = counting && tick;

   wdt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .por_n(por_n), .clr(sys_rst), .load(load),
      .load_val(load_val), .inc(inc), .at_max(at_max)
   );

   wdt_escalate u_esc (
      .clk(clk), .por_n(por_n), .sys_rst(sys_rst), .tick(tick),
      .at_max(at_max), .svc(svc), .wd_dis(wd_dis), .acc_err(acc_err),
      .proper_acc(proper_acc), .phase(phase), .go_warn(go_warn),
      .nmi(nmi), .rst_req(rst_req), .hold_rst(hold_rst)
   );
endmodule

// File: rtl/wdt_prewarn_chk.sv
module wdt_prewarn_chk
   import wdt_pkg::*;
(
   input logic       clk,
   input logic       por_n,
   input logic       sys_rst,
   input logic       wd_dis,
   input logic       acc_err,
   input wdt_phase_e phase,
   input logic       nmi,
   input logic       rst_req,
   input logic       hold_rst
);
   // R3: the prewarning interrupt lasts a single cycle
   assert_nmi_single_R3: assert property (@(posedge clk) disable iff (!por_n)
      nmi |=> !nmi);

   // R4: the reset request is held until system reset arrives
   assert_rst_held_R4: assert property (@(posedge clk) disable iff (!por_n)
      (rst_req && !sys_rst) |=> rst_req);

   // R5: no interrupt while the reset request is pending
   assert_no_nmi_in_reset_R5: assert property (@(posedge clk) disable iff (!por_n)
      rst_req |-> !nmi);

   // R6: an access error in normal counting raises the interrupt next cycle
   assert_acc_err_warn_R6: assert property (@(posedge clk) disable iff (!por_n)
      (phase == PH_RUN && acc_err && !sys_rst) |=> nmi);

   // R7: with counting disabled and no access error, no interrupt follows
   assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!por_n)
      (phase == PH_RUN && wd_dis && !acc_err) |=> !nmi);

   // R8: the hold flag only rises together with a new reset request
   assert_hold_with_rst_R8: assert property (@(posedge clk) disable iff (!por_n)
      $rose(hold_rst) |-> $rose(rst_req));

   // R9: the hold flag is never cleared except by power-on reset
   assert_hold_sticky_R9: assert property (@(posedge clk) disable iff (!por_n)
      hold_rst |=> hold_rst);
endmodule

bind wdt_prewarn wdt_prewarn_chk u_chk (
   .clk(clk), .por_n(por_n), .sys_rst(sys_rst), .wd_dis(wd_dis),
   .acc_err(acc_err), .phase(phase), .nmi(nmi), .rst_req(rst_req),
   .hold_rst(hold_rst)
);

// File: tb/wdt_prewarn_tb.sv
module wdt_prewarn_tb;
   localparam int CLK_PERIOD = 10;
   localparam int DLO = 4;
   localparam int DHI = 16;
   localparam int GAP = 256;

   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        sys_rst = 1'b1;
   logic        svc = 1'b0;
   logic        wd_dis = 1'b0;
   logic        slow_sel = 1'b0;
   logic [15:0] reload_val = '0;
   logic        acc_err = 1'b0;
   logic        proper_acc = 1'b0;
   logic        nmi, rst_req, hold_rst;

   int checks = 0;
   int errors = 0;
   int edges = 0;
   int base = 0;
   int nmi_seen = 0;
   logic nmi_prev = 1'b0;
   logic rst_prev = 1'b0;

   typedef struct { bit is_rst; int rel; } evt_t;
   evt_t exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) edges <= edges + 1;

   wdt_prewarn #(.CNT_W(16), .DIV_LO(DLO), .DIV_HI(DHI), .WARN_GAP(GAP)) u_dut (
      .clk(clk), .por_n(por_n), .sys_rst(sys_rst), .svc(svc), .wd_dis(wd_dis),
      .slow_sel(slow_sel), .reload_val(reload_val), .acc_err(acc_err),
      .proper_acc(proper_acc), .nmi(nmi), .rst_req(rst_req), .hold_rst(hold_rst)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic expect_evt(input bit is_rst, input int rel);
      evt_t e;
      e.is_rst = is_rst;
      e.rel    = rel;
      exp_q.push_back(e);
   endtask

   task automatic got_evt(input bit is_rst, input string req);
      evt_t e;
      if (exp_q.size() == 0) begin
         check(1'b0, req, edges - base, -1);
      end else begin
         e = exp_q.pop_front();
         check(e.is_rst == is_rst, req, int'(is_rst), int'(e.is_rst));
         check(e.rel == edges - base, req, edges - base, e.rel);
      end
   endtask

   // monitor: compares events with the scoreboard queue
   always @(negedge clk) begin
      if (por_n) begin
         if (nmi_prev) check(nmi == 1'b0, "R3 nmi width", int'(nmi), 0);
         if (nmi) begin
            nmi_seen++;
            got_evt(1'b0, "R3/R5/R6 nmi timing");
         end
         if (rst_req && !rst_prev) got_evt(1'b1, "R2/R4 rst_req timing");
      end
      nmi_prev = nmi;
      rst_prev = rst_req;
   end

   task automatic release_with(input logic [15:0] rv);
      @(negedge clk);
      reload_val = rv;
      sys_rst = 1'b0;
      svc = 1'b1;
      base = edges;
      @(negedge clk);
      svc = 1'b0;
   endtask

   task automatic wait_rel(input int x);
      while (edges - base < x) @(negedge clk);
   endtask

   task automatic drain();
      while (exp_q.size() > 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic apply_sys_rst();
      @(negedge clk);
      sys_rst = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(nmi == 0 && rst_req == 0 && hold_rst == 0, "R1 reset state",
            int'({nmi, rst_req, hold_rst}), 0);
      por_n = 1'b1;
      repeat (2) @(negedge clk);

      // Fast ratio, overflow after 16 enables; service and error in prewarning ignored
      expect_evt(1'b0, DLO * 16);
      expect_evt(1'b1, DLO * 16 + DLO * GAP);
      release_with(16'hFFF0);
      wait_rel(200);
      svc = 1'b1; acc_err = 1'b1; reload_val = 16'h0000;
      @(negedge clk);
      svc = 1'b0; acc_err = 1'b0;
      drain();
      check(rst_req == 1'b1, "R4 rst_req held", int'(rst_req), 1);
      check(nmi_seen == 1, "R5 single nmi per prewarning", nmi_seen, 1);
      check(hold_rst == 1'b0, "R8 first reset no hold", int'(hold_rst), 0);
      apply_sys_rst();
      check(rst_req == 1'b0, "R4 cleared by sys_rst", int'(rst_req), 0);
      proper_acc = 1'b1;
      @(negedge clk);
      proper_acc = 1'b0;

      // Slow ratio, overflow after 8 enables
      slow_sel = 1'b1;
      expect_evt(1'b0, DHI * 8);
      expect_evt(1'b1, DHI * 8 + DHI * GAP);
      release_with(16'hFFF8);
      drain();
      check(hold_rst == 1'b0, "R8 proper access prevents hold", int'(hold_rst), 0);
      apply_sys_rst();
      slow_sel = 1'b0;

      // Disabled: no overflow; access error still escalates
      wd_dis = 1'b1;
      nmi_seen = 0;
      release_with(16'hFFFE);
      wait_rel(299);
      check(nmi_seen == 0 && rst_req == 0, "R7 disabled no nmi", nmi_seen, 0);
      expect_evt(1'b0, 300);
      expect_evt(1'b1, 300 + DLO * GAP);
      acc_err = 1'b1;
      @(negedge clk);
      acc_err = 1'b0;
      drain();
      check(hold_rst == 1'b1, "R8 double reset sets hold", int'(hold_rst), 1);
      wd_dis = 1'b0;

      apply_sys_rst();
      check(hold_rst == 1'b1, "R9 sys_rst keeps hold", int'(hold_rst), 1);
      proper_acc = 1'b1;
      @(negedge clk);
      proper_acc = 1'b0;
      @(negedge clk);
      check(hold_rst == 1'b1, "R9 proper_acc keeps hold", int'(hold_rst), 1);
      por_n = 1'b0;
      @(negedge clk);
      check(hold_rst == 1'b0 && rst_req == 0, "R9 por clears hold",
            int'({hold_rst, rst_req}), 0);
      por_n = 1'b1;
      @(negedge clk);

      // After power-on, one more watchdog reset must not set hold
      expect_evt(1'b0, DLO * 1);
      expect_evt(1'b1, DLO * 1 + DLO * GAP);
      release_with(16'hFFFF);
      drain();
      check(hold_rst == 1'b0, "R9 por cleared double mark", int'(hold_rst), 0);
      check(exp_q.size() == 0, "R2 all events seen", exp_q.size(), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule